// File: doc/BRIEF.md
# SDRAM Refresh Debt Tracker

This block paces SDRAM auto-refresh for a memory controller. It does not give out a single periodic strobe. A programmable interval timer adds one owed refresh to a debt counter each time it expires. While automatic refresh is on and the debt is nonzero, the block raises a request toward the controller's arbiter. Each grant acknowledge retires one owed refresh.

Software sets a lag limit. If the owed count ever climbs strictly above that limit, the block raises a sticky fault flag that stays up until software clears it by writing one. This tells software that the arbiter has starved refresh for too long.

While automatic refresh is off, software can send raw SDRAM command codes through a manual command port, for example to run the power-up initialization sequence. Each accepted write appears as a one-cycle strobe carrying the code. The command timing and the arbiter sit outside this block.

Top module: `sdram_refresh_tracker`

## Requirements
- R1: After reset, `auto_on`, `ref_req`, `debt`, `lag_err` and `cmd_stb` are 0 and `cmd_code` is 0.
- R2: While enabled, the interval timer expires once every `period` cycles, with `period` = 0 treated as 1. Each expiry adds one to `debt` at the following edge. The first increment lands `period` edges after the edge that sampled the enable write.
- R3: An `ref_ack` while `debt` is nonzero removes one from `debt`. An `ref_ack` while `debt` is 0 has no effect. An expiry and an acknowledge in the same cycle leave `debt` unchanged.
- R4: `debt` saturates at 255 and never wraps. An expiry at 255 without an acknowledge leaves it at 255.
- R5: `ref_req` is high exactly when automatic refresh is enabled and `debt` is nonzero.
- R6: `lag_err` rises at the edge after a cycle in which `debt` > `lag_limit`. A debt equal to the limit does not set it.
- R7: `lag_err` stays set until an `err_clr` pulse. If the debt is still over the limit in the clearing cycle, setting wins.
- R8: While automatic refresh is disabled, the timer and `debt` are held at zero and `ref_req` stays low.
- R9: A `mcmd_wr` while disabled gives `cmd_stb` high for exactly the next cycle, with `cmd_code` equal to the written 4-bit `mcmd_code`. A `mcmd_wr` while enabled gives no strobe and leaves `cmd_code` unchanged.
- R10: `en_wr` loads `en_wdata` into the enable bit, which is shown on `auto_on` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable value to write |
| period | input | 16 | Refresh interval in cycles |
| lag_limit | input | 8 | Maximum tolerated debt |
| err_clr | input | 1 | Write-one clear of the lag fault |
| ref_ack | input | 1 | Arbiter grant acknowledge for one refresh |
| mcmd_wr | input | 1 | Manual command write strobe |
| mcmd_code | input | 4 | Manual command code |
| auto_on | output | 1 | Automatic refresh enable state |
| ref_req | output | 1 | Refresh request to the arbiter |
| debt | output | 8 | Outstanding refresh count |
| lag_err | output | 1 | Sticky over-limit fault |
| cmd_stb | output | 1 | One-cycle manual command strobe |
| cmd_code | output | 4 | Last accepted manual command code |

## Verification
A timer that drifts by one count shows up at the `debt` output. Counting from the enable edge, the increment lands one edge early or late, so it is visible within a single interval. A debt counter that mishandles an expiry and an acknowledge in the same cycle, or that wraps at saturation, gives a `debt` value different from the expected one at the next edge. A wrong fault flag shows on `lag_err` one edge after the debt first passes the limit, or at the edge after a clear. A wrong enable gate shows on `ref_req` or `cmd_stb` in the very next cycle.

// File: rtl/sdram_rt_pkg.sv
package sdram_rt_pkg;
  localparam int unsigned DEF_PERIOD_W = 16;
  localparam int unsigned DEF_DEBT_W   = 8;
  localparam int unsigned DEF_CMD_W    = 4;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } debt_op_e;
endpackage

// File: rtl/rt_interval_timer.sv
module rt_interval_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire
);
  localparam int unsigned EXT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0]    cnt_ext;

  assign cnt_ext = {1'b0, cnt_q} + EXT_W'(1);
  assign expire  = run && (cnt_ext >= {1'b0, period});

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (expire) cnt_d = '0;
    else             cnt_d = cnt_q + PERIOD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rt_debt_counter.sv
module rt_debt_counter
  import sdram_rt_pkg::*;
#(
  parameter int unsigned DEBT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              expire,
  input  logic              ack,
  output logic [DEBT_W-1:0] debt
);
  localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};

  logic [DEBT_W-1:0] debt_q, debt_d;
  logic              ack_ok;
  debt_op_e          op;

  assign ack_ok = ack && (debt_q != '0);

  always_comb begin
    op = OP_HOLD;
    if (expire && !ack_ok)      op = OP_INC;
    else if (ack_ok && !expire) op = OP_DEC;
  end

  always_comb begin
    debt_d = debt_q;
    if (!run) begin
      debt_d = '0;
    end else begin
      unique case (op)
        OP_INC:  if (debt_q != DEBT_MAX) debt_d = debt_q + DEBT_W'(1);
        OP_DEC:  debt_d = debt_q - DEBT_W'(1);
        default: debt_d = debt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assign debt = debt_q;
endmodule

// File: rtl/rt_manual_cmd.sv
module rt_manual_cmd #(
  parameter int unsigned CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blocked,
  input  logic             wr,
  input  logic [CMD_W-1:0] code_in,
  output logic             stb,
  output logic [CMD_W-1:0] code_out
);
  logic             take;
  logic             stb_q;
  logic [CMD_W-1:0] code_q, code_d;

  assign take   = wr && !blocked;
  assign code_d = take ? code_in : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      code_q <= '0;
    end else begin
      stb_q  <= take;
      code_q <= code_d;
    end
  end

  assign stb      = stb_q;
  assign code_out = code_q;
endmodule

// File: rtl/sdram_refresh_tracker.sv
module sdram_refresh_tracker
  import sdram_rt_pkg::*;
#(
  parameter int unsigned PERIOD_W = DEF_PERIOD_W,
  parameter int unsigned DEBT_W   = DEF_DEBT_W,
  parameter int unsigned CMD_W    = DEF_CMD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_wr,
  input  logic                en_wdata,
  input  logic [PERIOD_W-1:0] period,
  input  logic [DEBT_W-1:0]   lag_limit,
  input  logic                err_clr,
  input  logic                ref_ack,
  input  logic                mcmd_wr,
  input  logic [CMD_W-1:0]    mcmd_code,
  output logic                auto_on,
  output logic                ref_req,
  output logic [DEBT_W-1:0]   debt,
  output logic                lag_err,
  output logic                cmd_stb,
  output logic [CMD_W-1:0]    cmd_code
);
  logic en_q, en_d;
  logic err_q, err_d;
  logic expire;
  logic [DEBT_W-1:0] debt_w;

  assign en_d  = en_wr ? en_wdata : en_q;
  assign err_d = (err_q && !err_clr) || (debt_w > lag_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      err_q <= err_d;
    end
  end

  rt_interval_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en_q),
    .period (period),
    .expire (expire)
  );

  rt_debt_counter #(.DEBT_W(DEBT_W)) u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en_q),
    .expire (expire),
    .ack    (ref_ack),
    .debt   (debt_w)
  );

  rt_manual_cmd #(.CMD_W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .blocked  (en_q),
    .wr       (mcmd_wr),
    .code_in  (mcmd_code),
    .stb      (cmd_stb),
    .code_out (cmd_code)
  );

  assign auto_on = en_q;
  assign ref_req = en_q && (debt_w != '0);
  assign debt    = debt_w;
  assign lag_err = err_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int unsigned DEBT_W = 8,
  parameter int unsigned CMD_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_wr,
  input logic              en_wdata,
  input logic [DEBT_W-1:0] lag_limit,
  input logic              err_clr,
  input logic              ref_ack,
  input logic              mcmd_wr,
  input logic              auto_on,
  input logic              ref_req,
  input logic [DEBT_W-1:0] debt,
  input logic              lag_err,
  input logic              cmd_stb,
  input logic [CMD_W-1:0]  cmd_code
);
  localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && debt == DMAX && !ref_ack && !(en_wr && !en_wdata)) |=> debt == DMAX);

  p_req_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_on |-> !ref_req);

  p_debt_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_on |=> debt == '0);

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (debt > lag_limit) |=> lag_err);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lag_err && !err_clr) |=> lag_err);

  p_stb_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mcmd_wr && auto_on) |=> (!cmd_stb && $stable(cmd_code)));

  p_ack_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && debt == '0 && ref_ack && !(en_wr && !en_wdata)) |=> debt <= DEBT_W'(1));
endmodule

bind sdram_refresh_tracker rt_checker #(.DEBT_W(DEBT_W), .CMD_W(CMD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_wr     (en_wr),
  .en_wdata  (en_wdata),
  .lag_limit (lag_limit),
  .err_clr   (err_clr),
  .ref_ack   (ref_ack),
  .mcmd_wr   (mcmd_wr),
  .auto_on   (auto_on),
  .ref_req   (ref_req),
  .debt      (debt),
  .lag_err   (lag_err),
  .cmd_stb   (cmd_stb),
  .cmd_code  (cmd_code)
);

// File: tb/tb_sdram_refresh_tracker.sv
module tb_sdram_refresh_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_wr, en_wdata, err_clr, ref_ack, mcmd_wr;
  logic [15:0] period;
  logic [7:0]  lag_limit;
  logic [3:0]  mcmd_code;
  logic        auto_on, ref_req, lag_err, cmd_stb;
  logic [7:0]  debt;
  logic [3:0]  cmd_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  bit       m_en, m_err, m_stb;
  int       m_cnt, m_debt;
  bit [3:0] m_code;

  always #10 clk = ~clk;

  sdram_refresh_tracker dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .period(period), .lag_limit(lag_limit), .err_clr(err_clr),
    .ref_ack(ref_ack), .mcmd_wr(mcmd_wr), .mcmd_code(mcmd_code),
    .auto_on(auto_on), .ref_req(ref_req), .debt(debt),
    .lag_err(lag_err), .cmd_stb(cmd_stb), .cmd_code(cmd_code)
  );

  function automatic int eff_period(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int next_debt(input bit en, input int d, input bit tick, input bit ack);
    bit a;
    a = ack && (d != 0);
    if (!en) return 0;
    if (tick && !a) return (d == 255) ? 255 : d + 1;
    if (a && !tick) return d - 1;
    return d;
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  task automatic check_all();
    chk("R10 auto_on", auto_on, m_en);
    chk("R2 R3 R4 debt", debt, m_debt);
    chk("R5 ref_req", ref_req, (m_en && m_debt != 0));
    chk("R6 R7 lag_err", lag_err, m_err);
    chk("R9 cmd_stb", cmd_stb, m_stb);
    chk("R9 cmd_code", cmd_code, m_code);
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    bit tick;
    @(posedge clk);
    tick = m_en && (m_cnt + 1 >= eff_period(period));
    m_err  = (m_err && !err_clr) || (m_debt > lag_limit);
    m_stb  = mcmd_wr && !m_en;
    if (mcmd_wr && !m_en) m_code = mcmd_code;
    m_debt = next_debt(m_en, m_debt, tick, ref_ack);
    m_cnt  = (!m_en || tick) ? 0 : m_cnt + 1;
    if (en_wr) m_en = en_wdata;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    en_wr = 0; err_clr = 0; ref_ack = 0; mcmd_wr = 0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 0; idle(); en_wdata = 0; period = 16'd3; lag_limit = 8'd2; mcmd_code = 4'h0;
    m_en = 0; m_err = 0; m_stb = 0; m_cnt = 0; m_debt = 0; m_code = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 auto_on", auto_on, 0);
    chk("R1 ref_req", ref_req, 0);
    chk("R1 debt", debt, 0);
    chk("R1 lag_err", lag_err, 0);
    chk("R1 cmd_stb", cmd_stb, 0);
    chk("R1 cmd_code", cmd_code, 0);
    rst_n = 1;
    step();

    // R9: manual command while disabled, and R8 debt held
    mcmd_wr = 1; mcmd_code = 4'hA; step();
    mcmd_wr = 0; step();
    chk("R8 debt held while off", debt, 0);

    // R10/R2: enable, period 3, limit 2; first expiry lands three edges later
    en_wr = 1; en_wdata = 1; step(); idle();
    step(); step();
    chk("R2 no debt before interval", debt, 0);
    step();
    chk("R2 debt after first interval", debt, 1);
    // R9: write while enabled ignored
    mcmd_wr = 1; mcmd_code = 4'h5; step(); mcmd_wr = 0;
    chk("R9 ignored strobe", cmd_stb, 0);
    chk("R9 code kept", cmd_code, 4'hA);
    repeat (8) step();
    chk("R6 err set over limit", lag_err, 1);
    // R7: clear while still over limit -> stays
    err_clr = 1; step(); err_clr = 0;
    chk("R7 set wins over clear", lag_err, 1);
    // drain with acks, including an ack while debt is zero
    ref_ack = 1; repeat (20) step(); ref_ack = 0;
    err_clr = 1; step(); err_clr = 0; step();
    chk("R7 cleared", lag_err, 0);

    // R4: saturation with period 0 (every cycle), limit 255
    period = 16'd0; lag_limit = 8'd255;
    repeat (270) step();
    chk("R4 saturated", debt, 255);
    ref_ack = 1; repeat (3) step(); ref_ack = 0;
    chk("R3 tick plus ack holds", debt, 255);

    // R8: disable clears debt
    en_wr = 1; en_wdata = 0; step(); idle(); step();
    chk("R8 debt zero when off", debt, 0);
    chk("R8 no req when off", ref_req, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      en_wr     = ($urandom % 64) == 0;
      en_wdata  = ($urandom % 4) != 0;
      err_clr   = ($urandom % 16) == 0;
      ref_ack   = ($urandom % 3) == 0;
      mcmd_wr   = ($urandom % 8) == 0;
      mcmd_code = 4'($urandom);
      if (($urandom % 200) == 0) period = 16'($urandom % 6);
      if (($urandom % 200) == 0) lag_limit = 8'($urandom % 5);
      step();
    end
    idle(); step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule